// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Unit

This unit sits beside the control path of a small 8-bit CPU and decides which of five hardware interrupt sources is served next. It watches the inputs continuously and latches edge events as they arrive. It acts only when the CPU signals that the current instruction has finished. At that point it picks the highest-ranked pending request. It then issues a one-cycle `taken` pulse with the 16-bit address at which the service routine starts.

The five sources are of three kinds:
- One critical source cannot be masked. It needs a rising edge that is still held high when the instruction boundary arrives.
- Three sources have fixed service addresses. They can be blocked by a software mask and by a global enable flag.
- One source is non-vectored and has no fixed address. For it the unit drives an active-low acknowledge and reads a restart opcode of the form `11NNN111` from the requesting device. The service address is then NNN×8.

Accepting any source other than the critical one clears the global enable. Software must set the enable again before another maskable source can be served. Pushing the return address and fetching the routine belong to the CPU and are outside this unit.

Top module: `ivu_top`

## Requirements
- R1: After reset `ack_n` is high, `taken` and `nonvec` are low and `vector` is zero. The global enable is off and all three mask bits are set, so no source other than the critical one can be accepted.
- R2: Requests are evaluated only at a clock edge where `insn_end` is high and no acknowledge sequence is running. A vectored source is reported by `taken` high for exactly one cycle, in the cycle after that edge.
- R3: When several sources are eligible at the same boundary, the winner follows the fixed ranking, highest first: `crit_req`, `edge_req`, `lvl_a_req`, `lvl_b_req`, `ext_req`.
- R4: The service addresses for the vectored sources are fixed: `crit_req` 0x0024, `edge_req` 0x003C, `lvl_a_req` 0x0034 and `lvl_b_req` 0x002C. For each of them `nonvec` is low.
- R5: `crit_req` is served regardless of the mask bits and the global enable, and accepting it leaves the global enable unchanged.
- R6: `crit_req` is eligible only after a rising edge, and only while it stays high. If it drops before the boundary, the request is cancelled. A level held high after being served does not trigger again.
- R7: A clock edge with `mask_we` high loads `mask_val`. Bit 2 blocks `edge_req`, bit 1 blocks `lvl_a_req` and bit 0 blocks `lvl_b_req`; a 1 blocks the source.
- R8: The global enable is set by `ien_set` and cleared by `ien_clr`. `edge_req`, `lvl_a_req`, `lvl_b_req` and `ext_req` are served only while it is set. Accepting any of them clears it, and this clear wins over a simultaneous `ien_set`.
- R9: A rising edge on `edge_req` is stored whatever the mask and enable state. The stored event is removed only when that source is served.
- R10: `lvl_a_req` and `lvl_b_req` are level-sensitive: a pulse that has gone low before the boundary is not served.
- R11: When `ext_req` wins, `ack_n` goes low for ACK_LEN cycles (default 1), starting in the cycle after the boundary, and `taken` stays low meanwhile. `op_in` is sampled on the last acknowledge cycle. In the cycle where `ack_n` returns high, `taken` and `nonvec` are high and `vector` equals `op_in[5:3]`×8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req | input | 1 | Non-maskable critical request (edge and hold) |
| edge_req | input | 1 | Maskable request, captured on a rising edge |
| lvl_a_req | input | 1 | Maskable level request, ranked above `lvl_b_req` |
| lvl_b_req | input | 1 | Maskable level request |
| ext_req | input | 1 | Maskable non-vectored request |
| insn_end | input | 1 | High on the last cycle of each instruction |
| ien_set | input | 1 | Set the global enable |
| ien_clr | input | 1 | Clear the global enable |
| mask_we | input | 1 | Load the mask register |
| mask_val | input | 3 | New mask bits (1 blocks a source) |
| op_in | input | OP_W | Restart opcode returned by the device during acknowledge |
| ack_n | output | 1 | Active-low acknowledge for the non-vectored source |
| taken | output | 1 | One-cycle pulse: a request has been accepted |
| vector | output | VEC_W | Service routine address, valid with `taken` |
| nonvec | output | 1 | High when `vector` came from the restart opcode |

## Verification
The bench raises several sources together and then removes the winner each time. A ranking mistake would therefore show up as the wrong address in the cycle that `taken` fires.

It checks the critical source in its two failing forms: a pulse that is dropped before the boundary, and a level that is simply held after service. A design that treated that input as pure level or pure edge would serve one of these when it should not. The bench also latches an edge-captured event while it is masked and then unmasks it. An implementation that gated the capture with the mask, or that never cleared the stored event, would either lose that interrupt or serve it twice.

Three distinct restart opcodes check the opcode-to-address mapping. They also check that the acknowledge falls and recovers in the expected cycles and that `taken` is withheld until the opcode is in.

// File: rtl/ivu_pkg.sv
`timescale 1ns/1ps
package ivu_pkg;

   localparam int unsigned NSRC     = 5;
   localparam int unsigned IDX_CRIT = 0;
   localparam int unsigned IDX_EDGE = 1;
   localparam int unsigned IDX_LVLA = 2;
   localparam int unsigned IDX_LVLB = 3;
   localparam int unsigned IDX_EXT  = 4;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_ACK  = 1'b1
   } seq_e;

   // service address of a one-hot grant among the vectored sources
   function automatic logic [7:0] fixed_target(input logic [NSRC-1:0] g);
      logic [7:0] t;
      t = 8'h00;
      if (g[IDX_CRIT])      t = 8'h24;
      else if (g[IDX_EDGE]) t = 8'h3C;
      else if (g[IDX_LVLA]) t = 8'h34;
      else if (g[IDX_LVLB]) t = 8'h2C;
      return t;
   endfunction

   // restart slot number times eight
   function automatic logic [7:0] restart_target(input logic [2:0] slot);
      return {2'b00, slot, 3'b000};
   endfunction

endpackage

// File: rtl/ivu_edge_catch.sv
`timescale 1ns/1ps
module ivu_edge_catch #(
   parameter bit NEED_HOLD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic take,
   output logic pend
);

   logic req_q;
   logic rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req;
   end

   assign rise = req & ~req_q;

   generate
      if (NEED_HOLD) begin : g_hold
         // pending event is cancelled as soon as the input falls
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pend <= 1'b0;
            else if (rise)           pend <= 1'b1;
            else if (~req || take)   pend <= 1'b0;
         end
      end else begin : g_latch
         // pending event survives until served
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pend <= 1'b0;
            else if (rise)   pend <= 1'b1;
            else if (take)   pend <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/ivu_ctl.sv
`timescale 1ns/1ps
module ivu_ctl #(
   parameter int MASK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien_set,
   input  logic              ien_clr,
   input  logic              mask_we,
   input  logic [MASK_W-1:0] mask_val,
   input  logic              maskable_take,
   output logic [MASK_W-1:0] mask_q,
   output logic              ien_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ien_q <= 1'b0;
      else if (maskable_take) ien_q <= 1'b0;
      else if (ien_clr)      ien_q <= 1'b0;
      else if (ien_set)      ien_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '1;
      else if (mask_we) mask_q <= mask_val;
   end

endmodule

// File: rtl/ivu_arb.sv
`timescale 1ns/1ps
module ivu_arb #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   // index 0 carries the highest rank
   always_comb begin
      logic seen;
      seen  = 1'b0;
      grant = '0;
      for (int i = 0; i < N; i++) begin
         grant[i] = req[i] & ~seen;
         seen     = seen | req[i];
      end
   end

   assign any = |req;

endmodule

// File: rtl/ivu_seq.sv
`timescale 1ns/1ps
module ivu_seq
   import ivu_pkg::*;
#(
   parameter int VEC_W   = 16,
   parameter int OP_W    = 8,
   parameter int ACK_LEN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [NSRC-1:0]  grant,
   input  logic [OP_W-1:0]  op_in,
   output logic             ack_n,
   output logic             busy,
   output logic             taken,
   output logic [VEC_W-1:0] vector,
   output logic             nonvec
);

   localparam int CNT_W = (ACK_LEN > 1) ? $clog2(ACK_LEN) : 1;

   seq_e state;
   logic ack_last;
   logic unused_op;

   assign unused_op = ^{op_in[OP_W-1:6], op_in[2:0]};

   generate
      if (ACK_LEN == 1) begin : g_single
         assign ack_last = 1'b1;
      end else begin : g_multi
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (state == SEQ_ACK) cnt <= cnt + 1'b1;
            else                       cnt <= '0;
         end
         assign ack_last = (cnt == CNT_W'(ACK_LEN - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         taken  <= 1'b0;
         vector <= '0;
         nonvec <= 1'b0;
      end else begin
         taken <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  if (grant[IDX_EXT]) begin
                     state <= SEQ_ACK;
                  end else begin
                     taken  <= 1'b1;
                     vector <= VEC_W'(fixed_target(grant));
                     nonvec <= 1'b0;
                  end
               end
            end
            SEQ_ACK: begin
               if (ack_last) begin
                  state  <= SEQ_IDLE;
                  taken  <= 1'b1;
                  vector <= VEC_W'(restart_target(op_in[5:3]));
                  nonvec <= 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign ack_n = (state != SEQ_ACK);
   assign busy  = (state != SEQ_IDLE);

endmodule

// File: rtl/ivu_top.sv
`timescale 1ns/1ps
module ivu_top
   import ivu_pkg::*;
#(
   parameter int VEC_W   = 16,
   parameter int OP_W    = 8,
   parameter int ACK_LEN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             crit_req,
   input  logic             edge_req,
   input  logic             lvl_a_req,
   input  logic             lvl_b_req,
   input  logic             ext_req,
   input  logic             insn_end,
   input  logic             ien_set,
   input  logic             ien_clr,
   input  logic             mask_we,
   input  logic [2:0]       mask_val,
   input  logic [OP_W-1:0]  op_in,
   output logic             ack_n,
   output logic             taken,
   output logic [VEC_W-1:0] vector,
   output logic             nonvec
);

   localparam int MASK_W = 3;

   if (VEC_W < 8) begin : g_bad_vec
      $error("ivu_top: VEC_W must hold an 8-bit service address");
   end
   if (OP_W < 6) begin : g_bad_op
      $error("ivu_top: OP_W must cover the restart slot field");
   end
   if (ACK_LEN < 1) begin : g_bad_ack
      $error("ivu_top: ACK_LEN must be at least one cycle");
   end

   logic              crit_pend;
   logic              edge_pend;
   logic [MASK_W-1:0] mask_q;
   logic              ien_q;
   logic [NSRC-1:0]   req;
   logic [NSRC-1:0]   grant;
   logic              any_req;
   logic              busy;
   logic              accept;

   assign accept = insn_end & ~busy & any_req;

   ivu_edge_catch #(.NEED_HOLD(1'b1)) u_crit (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (crit_req),
      .take (accept & grant[IDX_CRIT]),
      .pend (crit_pend)
   );

   ivu_edge_catch #(.NEED_HOLD(1'b0)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (edge_req),
      .take (accept & grant[IDX_EDGE]),
      .pend (edge_pend)
   );

   ivu_ctl #(.MASK_W(MASK_W)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ien_set      (ien_set),
      .ien_clr      (ien_clr),
      .mask_we      (mask_we),
      .mask_val     (mask_val),
      .maskable_take(accept & ~grant[IDX_CRIT]),
      .mask_q       (mask_q),
      .ien_q        (ien_q)
   );

   assign req[IDX_CRIT] = crit_pend & crit_req;
   assign req[IDX_EDGE] = edge_pend & ~mask_q[2] & ien_q;
   assign req[IDX_LVLA] = lvl_a_req & ~mask_q[1] & ien_q;
   assign req[IDX_LVLB] = lvl_b_req & ~mask_q[0] & ien_q;
   assign req[IDX_EXT]  = ext_req & ien_q;

   ivu_arb #(.N(NSRC)) u_arb (
      .req  (req),
      .grant(grant),
      .any  (any_req)
   );

   ivu_seq #(.VEC_W(VEC_W), .OP_W(OP_W), .ACK_LEN(ACK_LEN)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .accept(accept),
      .grant (grant),
      .op_in (op_in),
      .ack_n (ack_n),
      .busy  (busy),
      .taken (taken),
      .vector(vector),
      .nonvec(nonvec)
   );

endmodule

// File: rtl/ivu_chk.sv
`timescale 1ns/1ps
module ivu_chk #(
   parameter int VEC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             crit_req,
   input logic             insn_end,
   input logic             ack_n,
   input logic             taken,
   input logic [VEC_W-1:0] vector,
   input logic             nonvec,
   input logic             ien_q
);

   logic is_crit_vec;
   logic is_fixed_vec;

   assign is_crit_vec  = (vector == VEC_W'(8'h24));
   assign is_fixed_vec = is_crit_vec || (vector == VEC_W'(8'h3C)) ||
                         (vector == VEC_W'(8'h34)) || (vector == VEC_W'(8'h2C));

   // R2: a report follows either a boundary or an acknowledge cycle
   assert_report_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> ($past(insn_end) || !$past(ack_n)));

   // R4: vectored reports carry one of the four fixed addresses
   assert_fixed_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !nonvec) |-> is_fixed_vec);

   // R6: the critical source was still high at the accepting edge
   assert_crit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !nonvec && is_crit_vec) |-> $past(crit_req));

   // R8: serving a vectored maskable source leaves the enable cleared
   assert_ien_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !nonvec && !is_crit_vec) |-> !ien_q);

   // R11: no report while the acknowledge is low
   assert_ack_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> !taken);

   // R11: acknowledge release coincides with the non-vectored report
   assert_ack_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_n) |-> (taken && nonvec));

   // R11: restart address is a multiple of eight below 0x40
   assert_restart_vec_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && nonvec) |-> ((vector[2:0] == 3'b000) && ((vector >> 6) == '0)));

endmodule

bind ivu_top ivu_chk #(.VEC_W(VEC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .crit_req(crit_req),
   .insn_end(insn_end),
   .ack_n   (ack_n),
   .taken   (taken),
   .vector  (vector),
   .nonvec  (nonvec),
   .ien_q   (ien_q)
);

// File: tb/sim_ivu_top.sv
`timescale 1ns/1ps
module sim_ivu_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        crit_req = 1'b0, edge_req = 1'b0, lvl_a_req = 1'b0, lvl_b_req = 1'b0, ext_req = 1'b0;
   logic        insn_end = 1'b0, ien_set = 1'b0, ien_clr = 1'b0, mask_we = 1'b0;
   logic [2:0]  mask_val = 3'b000;
   logic [7:0]  op_in = 8'h00;
   logic        ack_n, taken, nonvec;
   logic [15:0] vector;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ivu_top u0 (
      .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .edge_req(edge_req),
      .lvl_a_req(lvl_a_req), .lvl_b_req(lvl_b_req), .ext_req(ext_req),
      .insn_end(insn_end), .ien_set(ien_set), .ien_clr(ien_clr),
      .mask_we(mask_we), .mask_val(mask_val), .op_in(op_in),
      .ack_n(ack_n), .taken(taken), .vector(vector), .nonvec(nonvec)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_ien();
      ien_set = 1'b1; tick(); ien_set = 1'b0;
   endtask

   task automatic write_mask(input logic [2:0] m);
      mask_we = 1'b1; mask_val = m; tick(); mask_we = 1'b0;
   endtask

   task automatic boundary_vec(input string rq, input logic [15:0] expv);
      insn_end = 1'b1; tick(); insn_end = 1'b0;
      chk(rq, "taken", taken, 1);
      chk(rq, "vector", vector, expv);
      chk(rq, "nonvec", nonvec, 0);
      tick();
      chk(rq, "pulse width", taken, 0);
   endtask

   task automatic boundary_none(input string rq);
      insn_end = 1'b1; tick(); insn_end = 1'b0;
      chk(rq, "no accept", taken, 0);
      chk(rq, "no acknowledge", ack_n, 1);
      tick();
      chk(rq, "still quiet", taken, 0);
   endtask

   task automatic boundary_ext(input string rq, input logic [7:0] op, input logic [15:0] expv);
      insn_end = 1'b1; tick(); insn_end = 1'b0;
      chk(rq, "ack low", ack_n, 0);
      chk(rq, "held during ack", taken, 0);
      op_in = op; tick(); op_in = 8'h00;
      chk(rq, "ack released", ack_n, 1);
      chk(rq, "taken", taken, 1);
      chk(rq, "nonvec", nonvec, 1);
      chk(rq, "vector", vector, expv);
      tick();
      chk(rq, "pulse width", taken, 0);
   endtask

   task automatic t_reset();
      chk("R1", "ack_n", ack_n, 1);
      chk("R1", "taken", taken, 0);
      chk("R1", "vector", vector, 0);
      chk("R1", "nonvec", nonvec, 0);
      lvl_a_req = 1'b1; lvl_b_req = 1'b1; ext_req = 1'b1; edge_req = 1'b1; tick();
      boundary_none("R1 enable off");
      ext_req = 1'b0; set_ien();
      boundary_none("R1 masks set");
      ien_clr = 1'b1; tick(); ien_clr = 1'b0;
      lvl_a_req = 1'b0; lvl_b_req = 1'b0; edge_req = 1'b0;
      write_mask(3'b000);
      // the edge captured above is still stored; enable and drain it (R9)
      set_ien();
      boundary_vec("R9 stored edge", 16'h003C);
      write_mask(3'b111);
   endtask

   task automatic t_crit();
      crit_req = 1'b1; tick(); tick();
      boundary_vec("R5 crit with enable off and masks set", 16'h0024);
      boundary_none("R6 held level no retrigger");
      crit_req = 1'b0; tick();
      crit_req = 1'b1; tick(); crit_req = 1'b0; tick();
      boundary_none("R6 dropped before boundary");
   endtask

   task automatic t_priority();
      write_mask(3'b000);
      set_ien();
      lvl_a_req = 1'b1; lvl_b_req = 1'b1; ext_req = 1'b1; edge_req = 1'b1; crit_req = 1'b1;
      tick(); tick();
      boundary_vec("R3 crit first", 16'h0024);
      crit_req = 1'b0;
      boundary_vec("R5 R3 enable kept, edge next", 16'h003C);
      boundary_none("R8 enable cleared by accept");
      set_ien();
      boundary_vec("R3 lvl_a next", 16'h0034);
      lvl_a_req = 1'b0; set_ien();
      boundary_vec("R3 lvl_b next", 16'h002C);
      lvl_b_req = 1'b0; set_ien();
      boundary_ext("R3 ext last", 8'hEF, 16'h0028);
      ext_req = 1'b0; edge_req = 1'b0; tick();
   endtask

   task automatic t_mask();
      write_mask(3'b001); set_ien();
      lvl_b_req = 1'b1;
      boundary_none("R7 bit0 blocks lvl_b");
      write_mask(3'b000);
      boundary_vec("R7 lvl_b unmasked", 16'h002C);
      write_mask(3'b010); set_ien();
      lvl_a_req = 1'b1;
      boundary_vec("R7 bit1 blocks lvl_a", 16'h002C);
      lvl_a_req = 1'b0; lvl_b_req = 1'b0;
      write_mask(3'b100); set_ien();
      edge_req = 1'b1; tick(); edge_req = 1'b0; tick();
      boundary_none("R7 bit2 blocks edge");
      write_mask(3'b000);
      boundary_vec("R9 edge latched while masked", 16'h003C);
      set_ien();
      boundary_none("R9 latch cleared when served");
   endtask

   task automatic t_enable();
      ien_set = 1'b1; tick(); ien_set = 1'b0;
      ien_clr = 1'b1; tick(); ien_clr = 1'b0;
      lvl_a_req = 1'b1;
      boundary_none("R8 cleared by ien_clr");
      set_ien();
      boundary_vec("R8 served when set", 16'h0034);
      boundary_none("R8 cleared after accept");
      lvl_a_req = 1'b0;
   endtask

   task automatic t_level();
      set_ien();
      lvl_a_req = 1'b1; tick(); lvl_a_req = 1'b0; tick();
      boundary_none("R10 lvl_a pulse gone");
      lvl_b_req = 1'b1; tick(); lvl_b_req = 1'b0; tick();
      boundary_none("R10 lvl_b pulse gone");
      ien_clr = 1'b1; tick(); ien_clr = 1'b0;
   endtask

   task automatic t_boundary();
      set_ien();
      lvl_b_req = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tick();
         chk("R2", "no accept without boundary", taken, 0);
      end
      boundary_vec("R2 accepted at boundary", 16'h002C);
      lvl_b_req = 1'b0;
   endtask

   task automatic t_ext();
      set_ien(); ext_req = 1'b1;
      boundary_ext("R11 slot 7", 8'hFF, 16'h0038);
      set_ien();
      boundary_ext("R11 slot 0", 8'hC7, 16'h0000);
      set_ien();
      boundary_ext("R11 slot 2", 8'hD7, 16'h0010);
      ext_req = 1'b0; tick();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_crit();
      t_priority();
      t_mask();
      t_enable();
      t_level();
      t_boundary();
      t_ext();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule